// File: doc/BRIEF.md
# Floating-Bus Video Scan Address Generator

This block works out which main-RAM byte the video circuit is fetching during the current CPU cycle. The byte is needed when the processor reads an I/O location that nothing answers. On such a read the data bus still holds whatever the video fetch left on it. A system model can therefore answer the read with the RAM byte at the address this block produces.

The block takes a cycle count that restarts at every frame and the four display-mode flags: text, hi-res, store-mode and page 2. It splits the count into a scan line and a horizontal tick. It then turns these into horizontal and vertical counters and scrambles them into the interleaved video address. Last, it places that address in the text/low-res window or the hi-res window according to the display mode.

The processor's bus address and read strobe are also inputs. A read that falls in the unconnected range raises a valid strobe in the same cycle as the matching address. The result is registered twice, so `scan_addr` and `scan_valid` reflect the inputs two clock edges earlier.

Top module: `fbus_scan_addr`

## Requirements
- R1: The frame cycle count splits into a line number, equal to count / 65, and a tick, equal to count mod 65.
- R2: The horizontal counter is tick minus 1. Ticks 0 and 1 both give horizontal counter 0, so those two cycles yield the same address.
- R3: The vertical counter is the low 8 bits of line number plus 0xFA.
- R4: The row term is 0xD + hcount[5:3] + (vcount[7:6] | vcount[7:6]<<2). The base address places vcount[5:3] at bits 9:7, the row term's low four bits at bits 6:3, and hcount[2:0] at bits 2:0.
- R5: When the text flag is set, or the hi-res flag is clear, the base address gets 0x0800 if page 2 is set and store-mode is clear. Otherwise it gets 0x0400.
- R6: When the text flag is clear and the hi-res flag is set, the base address gets 0x4000 if page 2 is set and store-mode is clear, otherwise 0x2000. In this mode vcount[2:0] is also placed at bits 12:10.
- R7: With store-mode set, the page-2 flag has no effect: the address stays in page 1 (bit 11 clear in text mode, bit 14 clear in hi-res mode).
- R8: `scan_valid` is high exactly when, two cycles earlier, `bus_rd` was high and `bus_addr` lay within 0xC020..0xC02F inclusive. Reads outside that range, and cycles without a read, give `scan_valid` low.
- R9: `scan_addr` is the address computed from the frame count and flags sampled two rising edges earlier. It is always a main-RAM address below 0x6000.
- R10: After reset, `scan_valid` and `scan_addr` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_cycle | input | 15 | CPU cycles since start of frame |
| text_mode | input | 1 | Text display flag |
| hires_mode | input | 1 | Hi-res graphics flag |
| store_mode | input | 1 | Store-mode flag, forces page 1 |
| page2_sel | input | 1 | Display page 2 flag |
| bus_addr | input | 16 | Processor bus address |
| bus_rd | input | 1 | Processor read strobe |
| scan_addr | output | 16 | Main-RAM address of the current video fetch |
| scan_valid | output | 1 | Marks an unconnected-range read |

## Verification
A bad line/tick split shifts the address by a whole row, or moves it within a row, two cycles after the count is applied. This is caught at the line boundaries (counts 64 and 65) and at the doubled zero tick. A wrong vertical offset or row-term bias scrambles bits 9:3 on every address. Mode and page faults move the address into the wrong window, which the window and page-1 checks expose on the next valid output. A decoding fault shows up as a missing or spurious `scan_valid` at the range edges 0xC01F, 0xC020, 0xC02F and 0xC030.

// File: rtl/fbus_pkg.sv
package fbus_pkg;
  typedef struct packed {
    logic text;
    logic hires;
    logic store;
    logic page2;
  } disp_mode_t;
endpackage

// File: rtl/fbus_line_split.sv
module fbus_line_split
  import fbus_pkg::*;
#(
  parameter int CYC_W       = 15,
  parameter int LINE_CYCLES = 65,
  localparam int TICK_W     = $clog2(LINE_CYCLES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CYC_W-1:0]  cyc_in,
  input  disp_mode_t        mode_in,
  input  logic              hit_in,
  output logic [CYC_W-1:0]  line_q,
  output logic [TICK_W-1:0] tick_q,
  output disp_mode_t        mode_q,
  output logic              hit_q
);
  logic [CYC_W-1:0] line_w;
  logic [CYC_W-1:0] rem_w;

  always_comb begin
    line_w = cyc_in / CYC_W'(LINE_CYCLES);
    rem_w  = cyc_in - line_w * CYC_W'(LINE_CYCLES);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      tick_q <= '0;
      mode_q <= '0;
      hit_q  <= 1'b0;
    end else begin
      line_q <= line_w;
      tick_q <= rem_w[TICK_W-1:0];
      mode_q <= mode_in;
      hit_q  <= hit_in;
    end
  end

  // R1: the registered tick never reaches a full line length
  p_tick_range_r1: assert property (@(posedge clk) disable iff (rst)
    tick_q < TICK_W'(LINE_CYCLES));
endmodule

// File: rtl/fbus_row_map.sv
module fbus_row_map #(
  parameter int       CYC_W    = 15,
  parameter int       TICK_W   = 7,
  parameter logic [7:0] VBASE  = 8'hFA,
  parameter logic [3:0] ROW_BIAS = 4'hD
) (
  input  logic [CYC_W-1:0]  line_in,
  input  logic [TICK_W-1:0] tick_in,
  output logic [9:0]        base_addr,
  output logic [2:0]        vlow
);
  logic [TICK_W-1:0] hcnt;
  logic [CYC_W-1:0]  vsum;
  logic [7:0]        vcnt;
  logic [3:0]        row_term;
  logic [1:0]        vtop;

  always_comb begin
    hcnt     = (tick_in == '0) ? '0 : tick_in - TICK_W'(1);
    vsum     = line_in + CYC_W'(VBASE);
    vcnt     = vsum[7:0];
    vtop     = vcnt[7:6];
    row_term = ROW_BIAS + {1'b0, hcnt[5:3]} + ({2'b00, vtop} | {vtop, 2'b00});
    base_addr = {vcnt[5:3], row_term, hcnt[2:0]};
    vlow      = vcnt[2:0];
  end
endmodule

// File: rtl/fbus_page_sel.sv
module fbus_page_sel
  import fbus_pkg::*;
#(
  parameter logic [15:0] TEXT_P1 = 16'h0400,
  parameter logic [15:0] TEXT_P2 = 16'h0800,
  parameter logic [15:0] GFX_P1  = 16'h2000,
  parameter logic [15:0] GFX_P2  = 16'h4000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [9:0]  base_addr,
  input  logic [2:0]  vlow,
  input  disp_mode_t  mode_in,
  input  logic        hit_in,
  output logic [15:0] addr_q,
  output logic        valid_q
);
  logic        gfx_w;
  logic        alt_w;
  logic [15:0] addr_w;
  logic        gfx_q;
  logic        store_q;

  always_comb begin
    gfx_w = !mode_in.text && mode_in.hires;
    alt_w = !mode_in.store && mode_in.page2;
    if (gfx_w)
      addr_w = (alt_w ? GFX_P2 : GFX_P1) | {3'b000, vlow, base_addr};
    else
      addr_w = (alt_w ? TEXT_P2 : TEXT_P1) | {6'b000000, base_addr};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
      gfx_q   <= 1'b0;
      store_q <= 1'b0;
    end else begin
      addr_q  <= addr_w;
      valid_q <= hit_in;
      gfx_q   <= gfx_w;
      store_q <= mode_in.store;
    end
  end

  // R5: text/low-res fetches stay within 0x0400..0x0FFF
  p_text_window_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !gfx_q) |-> (addr_q >= 16'h0400 && addr_q < 16'h1000));
  // R6: hi-res fetches stay within 0x2000..0x5FFF
  p_gfx_window_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_q && gfx_q) |-> (addr_q >= 16'h2000 && addr_q < 16'h6000));
  // R7: store-mode pins the fetch to page 1
  p_store_page1_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_q && store_q) |-> (gfx_q ? !addr_q[14] : !addr_q[11]));
endmodule

// File: rtl/fbus_scan_addr.sv
module fbus_scan_addr
  import fbus_pkg::*;
#(
  parameter int          CYC_W       = 15,
  parameter int          LINE_CYCLES = 65,
  parameter logic [7:0]  VBASE       = 8'hFA,
  parameter logic [3:0]  ROW_BIAS    = 4'hD,
  parameter logic [15:0] FLOAT_LO    = 16'hC020,
  parameter logic [15:0] FLOAT_HI    = 16'hC02F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CYC_W-1:0] frame_cycle,
  input  logic             text_mode,
  input  logic             hires_mode,
  input  logic             store_mode,
  input  logic             page2_sel,
  input  logic [15:0]      bus_addr,
  input  logic             bus_rd,
  output logic [15:0]      scan_addr,
  output logic             scan_valid
);
  localparam int TICK_W = $clog2(LINE_CYCLES);

  disp_mode_t        mode_w;
  disp_mode_t        mode_s1;
  logic              hit_w;
  logic              hit_s1;
  logic [CYC_W-1:0]  line_s1;
  logic [TICK_W-1:0] tick_s1;
  logic [9:0]        base_w;
  logic [2:0]        vlow_w;

  always_comb begin
    mode_w = '{text: text_mode, hires: hires_mode, store: store_mode, page2: page2_sel};
    hit_w  = bus_rd && (bus_addr >= FLOAT_LO) && (bus_addr <= FLOAT_HI);
  end

  fbus_line_split #(
    .CYC_W(CYC_W), .LINE_CYCLES(LINE_CYCLES)
  ) u_split (
    .clk(clk), .rst(rst), .cyc_in(frame_cycle), .mode_in(mode_w), .hit_in(hit_w),
    .line_q(line_s1), .tick_q(tick_s1), .mode_q(mode_s1), .hit_q(hit_s1)
  );

  fbus_row_map #(
    .CYC_W(CYC_W), .TICK_W(TICK_W), .VBASE(VBASE), .ROW_BIAS(ROW_BIAS)
  ) u_row (
    .line_in(line_s1), .tick_in(tick_s1), .base_addr(base_w), .vlow(vlow_w)
  );

  fbus_page_sel u_page (
    .clk(clk), .rst(rst), .base_addr(base_w), .vlow(vlow_w), .mode_in(mode_s1),
    .hit_in(hit_s1), .addr_q(scan_addr), .valid_q(scan_valid)
  );

  // R8: an unconnected-range read yields a valid strobe two edges later
  p_valid_lat_r8: assert property (@(posedge clk) disable iff (rst)
    hit_w |-> ##2 scan_valid);
  // R9: every produced address lies in low main RAM
  p_main_ram_r9: assert property (@(posedge clk) disable iff (rst)
    scan_valid |-> (scan_addr < 16'h6000));
  // R10: reset clears the outputs
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (!scan_valid && scan_addr == 16'h0000));
endmodule

// File: tb/fbus_scan_addr_tb.sv
`timescale 1ns/1ps
module fbus_scan_addr_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [14:0] frame_cycle;
  logic        text_mode, hires_mode, store_mode, page2_sel;
  logic [15:0] bus_addr;
  logic        bus_rd;
  logic [15:0] scan_addr;
  logic        scan_valid;
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  fbus_scan_addr u_dut (
    .clk(clk), .rst(rst), .frame_cycle(frame_cycle), .text_mode(text_mode),
    .hires_mode(hires_mode), .store_mode(store_mode), .page2_sel(page2_sel),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .scan_addr(scan_addr), .scan_valid(scan_valid)
  );

  function automatic logic [15:0] model(int c, bit t, bit h, bit s, bit p);
    int ln, tk, hc, vc, rs, b;
    bit alt;
    ln = c / 65; tk = c % 65;
    hc = (tk == 0) ? 0 : tk - 1;
    vc = (ln + 'hFA) & 'hFF;
    rs = 13 + ((hc >> 3) & 7) + (((vc >> 6) & 3) | (((vc >> 6) & 3) << 2));
    b  = (((vc >> 3) & 7) << 7) | ((rs & 15) << 3) | (hc & 7);
    alt = !s && p;
    if (t || !h) b = b | (alt ? 'h800 : 'h400);
    else b = b | (alt ? 'h4000 : 'h2000) | ((vc & 7) << 10);
    return 16'(b);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(int c, bit t, bit h, bit s, bit p, logic [15:0] a, bit rd);
    @(negedge clk);
    frame_cycle = 15'(c); text_mode = t; hires_mode = h;
    store_mode = s; page2_sel = p; bus_addr = a; bus_rd = rd;
    repeat (2) @(posedge clk);
    #2;
  endtask

  task automatic t_reset;
    rst = 1'b1; frame_cycle = '0; text_mode = 1'b1; hires_mode = 1'b0;
    store_mode = 1'b0; page2_sel = 1'b0; bus_addr = '0; bus_rd = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R10 addr", 32'(scan_addr), 32'h0);
    check("R10 valid", 32'(scan_valid), 32'h0);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic t_split;
    apply(0, 1, 0, 0, 0, 16'hC020, 1);
    check("R4 cycle0", 32'(scan_addr), 32'h07E0);
    check("R2 cycle0", 32'(scan_addr), 32'(model(0, 1, 0, 0, 0)));
    apply(1, 1, 0, 0, 0, 16'hC020, 1);
    check("R2 tick1 equals tick0", 32'(scan_addr), 32'(model(0, 1, 0, 0, 0)));
    apply(64, 1, 0, 0, 0, 16'hC020, 1);
    check("R1 last tick", 32'(scan_addr), 32'(model(64, 1, 0, 0, 0)));
    apply(65, 1, 0, 0, 0, 16'hC020, 1);
    check("R1 next line", 32'(scan_addr), 32'(model(65, 1, 0, 0, 0)));
    apply(17029, 1, 0, 0, 0, 16'hC020, 1);
    check("R3 frame end", 32'(scan_addr), 32'(model(17029, 1, 0, 0, 0)));
    for (int c = 100; c < 17000; c += 997) begin
      apply(c, 1, 0, 0, 0, 16'hC025, 1);
      check("R4 sweep", 32'(scan_addr), 32'(model(c, 1, 0, 0, 0)));
    end
  endtask

  task automatic t_modes;
    apply(400, 1, 0, 0, 1, 16'hC020, 1);
    check("R5 text page2", 32'(scan_addr), 32'(model(400, 1, 0, 0, 1)));
    apply(400, 0, 0, 0, 0, 16'hC020, 1);
    check("R5 lores page1", 32'(scan_addr), 32'(model(400, 0, 0, 0, 0)));
    apply(400, 1, 1, 0, 0, 16'hC020, 1);
    check("R5 text wins over hires", 32'(scan_addr), 32'(model(400, 1, 1, 0, 0)));
    for (int c = 3; c < 17000; c += 1313) begin
      apply(c, 0, 1, 0, 0, 16'hC020, 1);
      check("R6 hires page1", 32'(scan_addr), 32'(model(c, 0, 1, 0, 0)));
      apply(c, 0, 1, 0, 1, 16'hC020, 1);
      check("R6 hires page2", 32'(scan_addr), 32'(model(c, 0, 1, 0, 1)));
    end
    apply(777, 1, 0, 1, 1, 16'hC020, 1);
    check("R7 store text", 32'(scan_addr), 32'(model(777, 1, 0, 0, 0)));
    apply(777, 0, 1, 1, 1, 16'hC020, 1);
    check("R7 store hires", 32'(scan_addr), 32'(model(777, 0, 1, 0, 0)));
  endtask

  task automatic t_decode;
    apply(10, 1, 0, 0, 0, 16'hC020, 1);
    check("R8 low edge", 32'(scan_valid), 32'h1);
    apply(10, 1, 0, 0, 0, 16'hC02F, 1);
    check("R8 high edge", 32'(scan_valid), 32'h1);
    apply(10, 1, 0, 0, 0, 16'hC01F, 1);
    check("R8 below range", 32'(scan_valid), 32'h0);
    apply(10, 1, 0, 0, 0, 16'hC030, 1);
    check("R8 above range", 32'(scan_valid), 32'h0);
    apply(10, 1, 0, 0, 0, 16'hC028, 0);
    check("R8 no read", 32'(scan_valid), 32'h0);
  endtask

  task automatic t_latency;
    apply(200, 1, 0, 0, 0, 16'hC020, 1);
    @(negedge clk);
    frame_cycle = 15'd5000; text_mode = 1'b0; hires_mode = 1'b1;
    @(posedge clk); #2;
    check("R9 one edge holds old", 32'(scan_addr), 32'(model(200, 1, 0, 0, 0)));
    @(posedge clk); #2;
    check("R9 two edges new", 32'(scan_addr), 32'(model(5000, 0, 1, 0, 0)));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_split();
    t_modes();
    t_decode();
    t_latency();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule